// File: doc/BRIEF.md
# Shared-Address Parallel I/O Port

This block is a 16-bit parallel port that a processor reaches at one decoded address. Reads return a 16-bit input word from an external source, such as a bank of switches. Writes load a 16-bit output register that drives an external sink, such as a row of indicators. Both directions sit at the same location, and the strobe that is asserted decides which path acts.

The bidirectional processor data bus is split into three parts: a bus-to-port input, a port-to-bus output, and a drive enable that would control a pad. Parameters choose the decode style:
- `MEM_SPACE` selects between the 8-bit I/O space with its own strobes and the full 16-bit memory space with memory strobes.
- `IGNORE_HI` leaves out that many of the uppermost compared address lines. The port then repeats across the address space in a predictable pattern.
- `PORT_ADDR` is the base address.

A combinational `hit_o` output shows where the decoder matches, so the aliasing pattern can be observed directly.

Top module: `shared_pio`

## Requirements
- R1: In I/O-space mode (`MEM_SPACE`=0), `hit_o` is high exactly when `addr_i[7:0]` equals `PORT_ADDR[7:0]`. Address lines 15..8 have no effect.
- R2: In memory-space mode (`MEM_SPACE`=1), the decoder compares the 16-bit address with bit 0 ignored. A 16-bit port therefore answers at both `PORT_ADDR` (even) and `PORT_ADDR`+1.
- R3: `IGNORE_HI`=k drops the top k compared lines. For example, k=6 in memory mode compares only bits 9..1, so a 1 KB window repeats 64 times. With `PORT_ADDR`=00DEh, addresses such as 04DEh and FCDEh hit, while 02DEh misses.
- R4: While `hit_o` is high, the selected read strobe is low and the selected write strobe is high, `data_oe_o` is 1 and `data_o` equals `pin_i`. Otherwise `data_oe_o` is 0 and `data_o` is all zeros.
- R5: On a rising `clk_i` edge where `hit_o` is high, the selected write strobe is low and the selected read strobe is high, `pout_o` takes the value of `data_i`.
- R6: With no qualifying write (address miss, or write strobe high), `pout_o` keeps its value across the clock edge.
- R7: When `hit_o` is high and both selected strobes are low, `err_o` is 1. In that case `data_oe_o` is 0 and `pout_o` does not load. In every other case `err_o` is 0.
- R8: The mode decides which strobe pair is used: `io_rd_ni`/`io_wr_ni` in I/O mode, `mem_rd_ni`/`mem_wr_ni` in memory mode. The other pair has no effect.
- R9: Driving `rst_ni` low clears `pout_o` to zero asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 16 | Processor address bus |
| io_rd_ni | input | 1 | I/O read strobe, active low |
| io_wr_ni | input | 1 | I/O write strobe, active low |
| mem_rd_ni | input | 1 | Memory read strobe, active low |
| mem_wr_ni | input | 1 | Memory write strobe, active low |
| data_i | input | 16 | Bus-to-port data |
| data_o | output | 16 | Port-to-bus data, zero when not driving |
| data_oe_o | output | 1 | Bus drive enable |
| pin_i | input | 16 | External input word |
| pout_o | output | 16 | Output register contents |
| hit_o | output | 1 | Address decode match |
| err_o | output | 1 | Both strobes asserted on a hit |

## Verification
The embedded assertions check the following on every cycle:
- The bus drive is enabled only under a clean read strobe, and the bus is zero whenever it is released.
- The output register holds its value whenever no write is qualified, and it loads exactly the presented word when a write is qualified.
- A strobe conflict never drives the bus and never changes the register.

Some behaviour can only be shown by the bench's scenarios against its own decode functions: the alias pattern each parameter setting produces, the word-pair span in memory mode, and the fact that the unselected strobe pair has no effect. The bench covers these by running an I/O-mode instance and a partially decoded memory-mode instance side by side.

// File: rtl/shared_pio_pkg.sv
package shared_pio_pkg;

  typedef logic [31:0] mask_t;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
  } strb_t;

  // bits lo..hi-1 set
  function automatic mask_t span_mask(input int lo, input int hi);
    mask_t m;
    for (int i = 0; i < 32; i++) m[i] = (i >= lo) && (i < hi);
    return m;
  endfunction

endpackage

// File: rtl/shared_pio_decode.sv
module shared_pio_decode #(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = '0,
  parameter logic [ADDR_W-1:0] MASK      = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  assign hit_o = ((addr_i ^ PORT_ADDR) & MASK) == '0;
endmodule

// File: rtl/shared_pio_strobe.sv
module shared_pio_strobe
  import shared_pio_pkg::*;
#(
  parameter bit MEM_SPACE = 1'b0
) (
  input  logic  io_rd_ni,
  input  logic  io_wr_ni,
  input  logic  mem_rd_ni,
  input  logic  mem_wr_ni,
  input  logic  hit_i,
  output strb_t sel_o,
  output logic  rd_en_o,
  output logic  wr_en_o,
  output logic  err_o
);
  generate
    if (MEM_SPACE) begin : g_mem
      logic unused_io;
      assign unused_io  = io_rd_ni & io_wr_ni;
      assign sel_o.rd_n = mem_rd_ni;
      assign sel_o.wr_n = mem_wr_ni;
    end else begin : g_io
      logic unused_mem;
      assign unused_mem = mem_rd_ni & mem_wr_ni;
      assign sel_o.rd_n = io_rd_ni;
      assign sel_o.wr_n = io_wr_ni;
    end
  endgenerate

  assign rd_en_o = hit_i & ~sel_o.rd_n &  sel_o.wr_n;
  assign wr_en_o = hit_i &  sel_o.rd_n & ~sel_o.wr_n;
  assign err_o   = hit_i & ~sel_o.rd_n & ~sel_o.wr_n;
endmodule

// File: rtl/shared_pio_oreg.sv
module shared_pio_oreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (ld_i) q_o <= d_i;
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));

  assert_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i));
endmodule

// File: rtl/shared_pio.sv
module shared_pio
  import shared_pio_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter int                IO_W      = 8,
  parameter bit                MEM_SPACE = 1'b0,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h002C,
  parameter int                IGNORE_HI = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              io_rd_ni,
  input  logic              io_wr_ni,
  input  logic              mem_rd_ni,
  input  logic              mem_wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] pin_i,
  output logic [DATA_W-1:0] pout_o,
  output logic              hit_o,
  output logic              err_o
);
  localparam int CMP_W = MEM_SPACE ? ADDR_W : IO_W;
  localparam int LO    = MEM_SPACE ? 1 : 0;  // word port spans a byte pair
  localparam int HI    = CMP_W - IGNORE_HI;
  localparam logic [ADDR_W-1:0] MASK = ADDR_W'(span_mask(LO, HI));

  strb_t sel;
  logic  rd_en, wr_en;

  shared_pio_decode #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .MASK(MASK)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit_o)
  );

  shared_pio_strobe #(.MEM_SPACE(MEM_SPACE)) u_strb (
    .io_rd_ni(io_rd_ni), .io_wr_ni(io_wr_ni),
    .mem_rd_ni(mem_rd_ni), .mem_wr_ni(mem_wr_ni),
    .hit_i(hit_o), .sel_o(sel),
    .rd_en_o(rd_en), .wr_en_o(wr_en), .err_o(err_o)
  );

  shared_pio_oreg #(.DATA_W(DATA_W)) u_oreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(wr_en),
    .d_i(data_i), .q_o(pout_o)
  );

  assign data_oe_o = rd_en;
  assign data_o    = rd_en ? pin_i : '0;

  assert_drive_needs_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (hit_o && !sel.rd_n && sel.wr_n && data_o == pin_i));

  assert_bus_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);

  assert_conflict_no_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !data_oe_o);

  assert_conflict_no_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> $stable(pout_o));
endmodule

// File: tb/shared_pio_test.sv
module shared_pio_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        io_rd_n = 1'b1, io_wr_n = 1'b1, mem_rd_n = 1'b1, mem_wr_n = 1'b1;
  logic [15:0] din = '0, pin = '0;
  logic [15:0] dout_a, pout_a, dout_b, pout_b;
  logic        oe_a, hit_a, err_a, oe_b, hit_b, err_b;
  logic [15:0] exp_a = '0, exp_b = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shared_pio #(.MEM_SPACE(1'b0), .PORT_ADDR(16'h002C), .IGNORE_HI(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .io_rd_ni(io_rd_n), .io_wr_ni(io_wr_n),
    .mem_rd_ni(mem_rd_n), .mem_wr_ni(mem_wr_n),
    .data_i(din), .data_o(dout_a), .data_oe_o(oe_a),
    .pin_i(pin), .pout_o(pout_a), .hit_o(hit_a), .err_o(err_a));

  shared_pio #(.MEM_SPACE(1'b1), .PORT_ADDR(16'h00DE), .IGNORE_HI(6)) uut_mem (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .io_rd_ni(io_rd_n), .io_wr_ni(io_wr_n),
    .mem_rd_ni(mem_rd_n), .mem_wr_ni(mem_wr_n),
    .data_i(din), .data_o(dout_b), .data_oe_o(oe_b),
    .pin_i(pin), .pout_o(pout_b), .hit_o(hit_b), .err_o(err_b));

  function automatic bit hit_io(input logic [15:0] a);
    return a[7:0] == 8'h2C;
  endfunction

  function automatic bit hit_mem(input logic [15:0] a);
    return a[9:1] == 9'h06F;  // 00DEh >> 1
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_comb;
    bit h, rd, er;
    h  = hit_io(addr);
    rd = h && !io_rd_n && io_wr_n;
    er = h && !io_rd_n && !io_wr_n;
    check(hit_a == h, "R1 io hit", hit_a, h);
    check(oe_a == rd, "R4 io oe", oe_a, rd);
    check(dout_a == (rd ? pin : 16'h0), "R4 io data", dout_a, rd ? pin : 16'h0);
    check(err_a == er, "R7 io err", err_a, er);
    h  = hit_mem(addr);
    rd = h && !mem_rd_n && mem_wr_n;
    er = h && !mem_rd_n && !mem_wr_n;
    check(hit_b == h, "R3 mem hit", hit_b, h);
    check(oe_b == rd, "R8 mem oe", oe_b, rd);
    check(dout_b == (rd ? pin : 16'h0), "R4 mem data", dout_b, rd ? pin : 16'h0);
    check(err_b == er, "R7 mem err", err_b, er);
  endtask

  task automatic apply(input logic [15:0] a, input logic [3:0] s,
                       input logic [15:0] d, input logic [15:0] p);
    @(negedge clk);
    addr = a; {io_rd_n, io_wr_n, mem_rd_n, mem_wr_n} = s; din = d; pin = p;
    #1;
    check_comb();
    if (hit_io(a) && io_rd_n && !io_wr_n) exp_a = d;
    if (hit_mem(a) && mem_rd_n && !mem_wr_n) exp_b = d;
    @(posedge clk);
    #1;
    check(pout_a == exp_a, "R5/R6 io reg", pout_a, exp_a);
    check(pout_b == exp_b, "R5/R6 mem reg", pout_b, exp_b);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    #1;
    check(pout_a == 16'h0 && pout_b == 16'h0, "R9 reset", {pout_a, pout_b}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // strobe order {io_rd, io_wr, mem_rd, mem_wr}, active low
    apply(16'hA52C, 4'b1011, 16'h1234, 16'h0);  // R1: io write, upper byte ignored
    apply(16'h002C, 4'b0111, 16'h0, 16'hBEEF);  // R4: io read
    apply(16'h00DF, 4'b1110, 16'h5A5A, 16'h0);  // R2: odd byte of word pair
    apply(16'hFCDE, 4'b1101, 16'h0, 16'hC0DE);  // R3: alias read
    apply(16'h02DE, 4'b1110, 16'hFFFF, 16'h0);  // R3: bit 9 set, miss
    check(pout_b == 16'h5A5A, "R3 miss no load", pout_b, 16'h5A5A);
    apply(16'h04DE, 4'b1110, 16'h0F0F, 16'h0);  // R3: bit 10 ignored, hit
    apply(16'h002C, 4'b0011, 16'h7777, 16'h1);  // R7: io conflict
    check(pout_a == 16'h1234, "R7 conflict no load", pout_a, 16'h1234);
    apply(16'h00DE, 4'b1100, 16'h8888, 16'h2);  // R7: mem conflict
    apply(16'h00DE, 4'b0011, 16'h9999, 16'h3);  // R8: io strobes on mem uut
    check(pout_b == 16'h0F0F, "R8 other pair ignored", pout_b, 16'h0F0F);
    apply(16'h002C, 4'b1100, 16'h4444, 16'h4);  // R8: mem strobes on io uut
    check(pout_a == 16'h1234, "R8 other pair ignored", pout_a, 16'h1234);

    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      case ($urandom % 4)
        0: a = 16'($urandom);
        1: a = {8'($urandom), 8'h2C};
        2: a = {6'($urandom), 9'h06F, 1'($urandom)};
        default: a = 16'h00DE ^ (16'h1 << ($urandom % 10));
      endcase
      apply(a, 4'($urandom), 16'($urandom), 16'($urandom));
    end

    @(negedge clk) rst_n = 1'b0;
    #1;
    check(pout_a == 16'h0 && pout_b == 16'h0, "R9 async clear", {pout_a, pout_b}, 0);
    exp_a = '0; exp_b = '0;
    @(negedge clk) rst_n = 1'b1;
    apply(16'h002C, 4'b1111, 16'hABCD, 16'h0);  // R6: idle strobes
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule